// File: doc/BRIEF.md
# Dual-Output Programmable Clock Divider

This block turns one master clock into two slower clock streams. Each stream is a one-cycle-wide clock-enable pulse that fires once per output period. The first stream, `out0`, comes from a power-of-two prescaler. A multiplexer can replace it with the undivided master rate. The second stream, `out1`, comes from a second power-of-two prescaler. That prescaler feeds a wide integer divider, which a configuration bit can bypass.

The divide ratios and mode bits are written through a flat parallel configuration port in one clock cycle. Two control pins gate the outputs at run time. A configuration bit sets the role of each pin: output enable, source select or power-down. A new ratio is held back until the running period ends, so a reconfiguration never shortens a period.

Top module: `dual_clkdiv`

## Requirements
- R1: While `rst_n` is low, both outputs are low and every configuration field reads as zero. With all fields zero, `out0` pulses on every cycle after the first clock edge following reset release. With all fields zero and `ctl1` high, `out1` pulses every second cycle.
- R2: The prescaler field selects the ratio: field value 0, 1, 2 or 3 divides by 1, 2, 4 or 8. With no gating, `out0` is high for exactly one cycle out of every ratio cycles.
- R3: `out1` has a period equal to the `cfg_pre1` ratio times N, where N = `cfg_div` + 2. The divider therefore covers every N from 2 (word 0) to 1025 (word 1023).
- R4: When `cfg_bypass` is 1, the integer divider is skipped and `out1` pulses once per `cfg_pre1` prescaler period.
- R5: A pulse of `cfg_we` stores every `cfg_*` field in one edge. A new `cfg_pre0` takes effect only after the next `out0` period ends. A new `cfg_pre1`, `cfg_div` or `cfg_bypass` takes effect only after the next `out1` period ends. The period that is running completes at its old length.
- R6: When `cfg_en0` or `cfg_pd0` is 1 and `ctl0` is low, `out0` is held low on the following cycle.
- R7: When `cfg_sel0` is 1 and `ctl0` is high, `out0` is high on every cycle (undivided master rate).
- R8: When `cfg_pd0` is 1 and `ctl0` is low, the `out0` counter is cleared and held. After `ctl0` returns high, the first `out0` pulse arrives one full period later.
- R9: `out1` is low on any cycle that follows a cycle in which `ctl1` was low. When `cfg_pd1` is 0, the `out1` counters keep running while `ctl1` is low.
- R10: When `cfg_pd1` is 1 and `ctl1` is low, both `out1` counters are cleared and held. After wake-up, the first `out1` pulse arrives one full period later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl0 | input | 1 | Control pin for output 0 (enable, select or power-down) |
| ctl1 | input | 1 | Control pin for output 1 (enable or power-down) |
| cfg_we | input | 1 | Stores all configuration fields on this edge |
| cfg_pre0 | input | 2 | Prescaler ratio code for output 0 |
| cfg_pre1 | input | 2 | Prescaler ratio code for output 1 |
| cfg_div | input | 10 | Divider word, N = value + 2 |
| cfg_bypass | input | 1 | Skip the integer divider on output 1 |
| cfg_en0 | input | 1 | `ctl0` acts as output enable for output 0 |
| cfg_sel0 | input | 1 | `ctl0` high selects the undivided rate for output 0 |
| cfg_pd0 | input | 1 | `ctl0` low powers down the output 0 counter |
| cfg_pd1 | input | 1 | `ctl1` low powers down the output 1 counters |
| out0 | output | 1 | Output 0 clock-enable pulse |
| out1 | output | 1 | Output 1 clock-enable pulse |

## Verification
The bench writes the configuration in the middle of a period and measures the period that follows. A design that adopted the new ratio at once would give a short period there. It also drives the divider word at both ends of its range. This catches an off-by-one in the N encoding, or a counter too narrow to reach divide-by-1025. Waking from power-down must start a full period. A design that only gated its output would instead resume from a stale count and pulse early. Mixed gating and select patterns on `ctl0` expose any confusion about which role the pin plays.

// File: rtl/dcd_pkg.sv
package dcd_pkg;
  parameter int unsigned PRE_W = 2;
  parameter int unsigned DIV_W = 10;
  localparam int unsigned PCNT_W = (1 << PRE_W) - 1;
  localparam int unsigned NCNT_W = DIV_W + 1;

  typedef struct packed {
    logic [PRE_W-1:0] pre0;
    logic [PRE_W-1:0] pre1;
    logic [DIV_W-1:0] div;
    logic             byp;
    logic             en0;
    logic             sel0;
    logic             pd0;
    logic             pd1;
  } dcd_cfg_t;

  // terminal count of a prescaler: ratio 2**code minus one
  function automatic logic [PCNT_W-1:0] pre_limit(input logic [PRE_W-1:0] code);
    pre_limit = PCNT_W'((1 << code) - 1);
  endfunction
endpackage

// File: rtl/dcd_prescale.sv
module dcd_prescale
  import dcd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             reload,
  input  logic [PRE_W-1:0] mode_new,
  output logic             tick,
  output logic             idle
);
  logic [PCNT_W-1:0] cnt_q, cnt_d;
  logic [PRE_W-1:0]  mode_q, mode_d;

  assign tick = (cnt_q == pre_limit(mode_q));
  assign idle = (cnt_q == '0);

  always_comb begin
    cnt_d  = cnt_q;
    mode_d = mode_q;
    if (!run) begin
      cnt_d  = '0;
      mode_d = mode_new;
    end else if (tick) begin
      cnt_d = '0;
      if (reload) mode_d = mode_new;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      mode_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      mode_q <= mode_d;
    end
  end
endmodule

// File: rtl/dcd_ndiv.sv
module dcd_ndiv
  import dcd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             step,
  input  logic [DIV_W-1:0] div_new,
  input  logic             byp_new,
  output logic             last,
  output logic             idle
);
  logic [NCNT_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0]  div_q, div_d;
  logic              byp_q, byp_d;
  logic [NCNT_W-1:0] term;

  // N = word + 2, so the count runs 0 .. word + 1
  assign term = {1'b0, div_q} + NCNT_W'(1);
  assign last = byp_q | (cnt_q == term);
  assign idle = (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    div_d = div_q;
    byp_d = byp_q;
    if (!run) begin
      cnt_d = '0;
      div_d = div_new;
      byp_d = byp_new;
    end else if (step) begin
      if (last) begin
        cnt_d = '0;
        div_d = div_new;
        byp_d = byp_new;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      div_q <= '0;
      byp_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      div_q <= div_d;
      byp_q <= byp_d;
    end
  end
endmodule

// File: rtl/dual_clkdiv.sv
module dual_clkdiv
  import dcd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl0,
  input  logic             ctl1,
  input  logic             cfg_we,
  input  logic [PRE_W-1:0] cfg_pre0,
  input  logic [PRE_W-1:0] cfg_pre1,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             cfg_bypass,
  input  logic             cfg_en0,
  input  logic             cfg_sel0,
  input  logic             cfg_pd0,
  input  logic             cfg_pd1,
  output logic             out0,
  output logic             out1
);
  dcd_cfg_t cfg_q, cfg_d;
  logic     out0_d, out1_d;
  logic     pw0, gate0, mux0, tick0, p0_idle;
  logic     pw1, tick1, last1, end1, p1_idle, n_idle;

  // configuration shadow
  always_comb begin
    cfg_d = cfg_q;
    if (cfg_we) begin
      cfg_d.pre0 = cfg_pre0;
      cfg_d.pre1 = cfg_pre1;
      cfg_d.div  = cfg_div;
      cfg_d.byp  = cfg_bypass;
      cfg_d.en0  = cfg_en0;
      cfg_d.sel0 = cfg_sel0;
      cfg_d.pd0  = cfg_pd0;
      cfg_d.pd1  = cfg_pd1;
    end
  end

  // pin roles
  assign pw0   = ~cfg_q.pd0 | ctl0;
  assign gate0 = ~(cfg_q.en0 | cfg_q.pd0) | ctl0;
  assign mux0  = cfg_q.sel0 & ctl0;
  assign pw1   = ~cfg_q.pd1 | ctl1;

  dcd_prescale u_pre0 (
    .clk(clk), .rst_n(rst_n), .run(pw0), .reload(tick0),
    .mode_new(cfg_q.pre0), .tick(tick0), .idle(p0_idle)
  );

  dcd_prescale u_pre1 (
    .clk(clk), .rst_n(rst_n), .run(pw1), .reload(end1),
    .mode_new(cfg_q.pre1), .tick(tick1), .idle(p1_idle)
  );

  dcd_ndiv u_ndiv (
    .clk(clk), .rst_n(rst_n), .run(pw1), .step(tick1),
    .div_new(cfg_q.div), .byp_new(cfg_q.byp), .last(last1), .idle(n_idle)
  );

  assign end1 = tick1 & last1;

  always_comb begin
    out0_d = pw0 & gate0 & (mux0 | tick0);
    out1_d = ctl1 & end1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      out0  <= 1'b0;
      out1  <= 1'b0;
    end else begin
      cfg_q <= cfg_d;
      out0  <= out0_d;
      out1  <= out1_d;
    end
  end
endmodule

// File: rtl/dcd_checker.sv
module dcd_checker
  import dcd_pkg::*;
(
  input logic     clk,
  input logic     rst_n,
  input logic     ctl0,
  input logic     ctl1,
  input dcd_cfg_t cfg,
  input logic     out0,
  input logic     out1,
  input logic     p0_idle,
  input logic     p1_idle,
  input logic     n_idle
);
  AST_GATE0_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ((cfg.en0 | cfg.pd0) && !ctl0) |=> !out0); // R6

  AST_SEL0_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.sel0 && ctl0) |=> out0); // R7

  AST_PD0_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.pd0 && !ctl0) |=> p0_idle); // R8

  AST_GATE1_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl1 |=> !out1); // R9

  AST_PD1_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.pd1 && !ctl1) |=> (p1_idle && n_idle)); // R10
endmodule

bind dual_clkdiv dcd_checker u_chk (
  .clk(clk), .rst_n(rst_n), .ctl0(ctl0), .ctl1(ctl1), .cfg(cfg_q),
  .out0(out0), .out1(out1), .p0_idle(p0_idle), .p1_idle(p1_idle), .n_idle(n_idle)
);

// File: tb/dual_clkdiv_tb_top.sv
module dual_clkdiv_tb_top;
  logic       clk = 1'b0;
  logic       rst_n, ctl0, ctl1, cfg_we;
  logic [1:0] cfg_pre0, cfg_pre1;
  logic [9:0] cfg_div;
  logic       cfg_bypass, cfg_en0, cfg_sel0, cfg_pd0, cfg_pd1;
  logic       out0, out1;

  int    nchk = 0;
  int    nerr = 0;
  int    cyc  = 0;
  bit    chk_on = 1'b0;
  string tag = "R1";

  // model state
  int s_pre0, s_pre1, s_div, s_byp, s_en0, s_sel0, s_pd0, s_pd1;
  int m0c, m0m, m1c, m1m, mnc, mnd, mnb;
  logic e0 = 1'b0, e1 = 1'b0;

  always #4 clk = ~clk;

  dual_clkdiv dut_i (
    .clk(clk), .rst_n(rst_n), .ctl0(ctl0), .ctl1(ctl1), .cfg_we(cfg_we),
    .cfg_pre0(cfg_pre0), .cfg_pre1(cfg_pre1), .cfg_div(cfg_div),
    .cfg_bypass(cfg_bypass), .cfg_en0(cfg_en0), .cfg_sel0(cfg_sel0),
    .cfg_pd0(cfg_pd0), .cfg_pd1(cfg_pd1), .out0(out0), .out1(out1)
  );

  // behavioural reference, one step per clock
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_pre0 = 0; s_pre1 = 0; s_div = 0; s_byp = 0;
      s_en0 = 0; s_sel0 = 0; s_pd0 = 0; s_pd1 = 0;
      m0c = 0; m0m = 0; m1c = 0; m1m = 0; mnc = 0; mnd = 0; mnb = 0;
      e0 = 1'b0; e1 = 1'b0;
    end else begin
      bit t0, t1, last, fin, awake0, awake1, pass0;
      t0     = (m0c == (1 << m0m) - 1);
      awake0 = (s_pd0 == 0) || ctl0;
      pass0  = ((s_en0 == 0) && (s_pd0 == 0)) || ctl0;
      e0     = awake0 && pass0 && (((s_sel0 != 0) && ctl0) || t0);
      if (!awake0 || t0) begin m0c = 0; m0m = s_pre0; end
      else m0c++;
      t1     = (m1c == (1 << m1m) - 1);
      last   = (mnb != 0) || (mnc == mnd + 1);
      fin    = t1 && last;
      awake1 = (s_pd1 == 0) || ctl1;
      e1     = ctl1 && fin;
      if (!awake1) begin
        m1c = 0; mnc = 0; m1m = s_pre1; mnd = s_div; mnb = s_byp;
      end else if (t1) begin
        m1c = 0;
        if (last) begin mnc = 0; m1m = s_pre1; mnd = s_div; mnb = s_byp; end
        else mnc++;
      end else m1c++;
      if (cfg_we) begin
        s_pre0 = cfg_pre0; s_pre1 = cfg_pre1; s_div = cfg_div; s_byp = cfg_bypass;
        s_en0 = cfg_en0; s_sel0 = cfg_sel0; s_pd0 = cfg_pd0; s_pd1 = cfg_pd1;
      end
    end
  end

  task automatic chk(input logic got, input logic exp, input string what);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s %s: got %0b expected %0b at cycle %0d", tag, what, got, exp, cyc);
    end
  endtask

  task automatic chk_int(input int got, input int exp, input string what);
    nchk++;
    if (got != exp) begin
      nerr++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  always @(negedge clk) if (chk_on) begin
    chk(out0, e0, "out0");
    chk(out1, e1, "out1");
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      nerr++;
      $display("FAIL %s watchdog: got %0d cycles expected completion", tag, cyc);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int p0, input int p1, input int dv, input bit byp,
                    input bit en0, input bit sel0, input bit pd0, input bit pd1);
    cfg_pre0 = 2'(p0); cfg_pre1 = 2'(p1); cfg_div = 10'(dv); cfg_bypass = byp;
    cfg_en0 = en0; cfg_sel0 = sel0; cfg_pd0 = pd0; cfg_pd1 = pd1;
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_pulse1();
    do @(negedge clk); while (!out1);
  endtask

  task automatic gap1(output int g);
    g = 0;
    do begin @(negedge clk); g++; end while (!out1);
  endtask

  initial begin
    int g;
    rst_n = 1'b0; ctl0 = 1'b0; ctl1 = 1'b1; cfg_we = 1'b0;
    cfg_pre0 = '0; cfg_pre1 = '0; cfg_div = '0; cfg_bypass = 1'b0;
    cfg_en0 = 1'b0; cfg_sel0 = 1'b0; cfg_pd0 = 1'b0; cfg_pd1 = 1'b0;
    @(negedge clk);
    chk_on = 1'b1;
    tag = "R1"; run(3);
    rst_n = 1'b1; run(20);

    tag = "R2";
    wr(1, 0, 0, 0, 0, 0, 0, 0); run(40);
    wr(2, 0, 0, 0, 0, 0, 0, 0); run(40);
    wr(3, 0, 0, 0, 0, 0, 0, 0); run(60);

    tag = "R3";
    wr(0, 2, 3, 0, 0, 0, 0, 0); run(120);
    wr(0, 3, 50, 0, 0, 0, 0, 0); run(1300);
    wr(0, 0, 1023, 0, 0, 0, 0, 0);
    wait_pulse1(); wait_pulse1();
    gap1(g); chk_int(g, 1025, "out1 period at N=1025");
    wr(0, 0, 0, 0, 0, 0, 0, 0);
    wait_pulse1(); wait_pulse1();
    gap1(g); chk_int(g, 2, "out1 period at N=2");

    tag = "R4";
    wr(0, 1, 7, 1, 0, 0, 0, 0); run(40);
    wr(0, 0, 7, 1, 0, 0, 0, 0); run(20);

    tag = "R5";
    wr(0, 0, 8, 0, 0, 0, 0, 0);
    wait_pulse1(); wait_pulse1();
    wr(0, 0, 0, 0, 0, 0, 0, 0);
    g = 1;
    do begin @(negedge clk); g++; end while (!out1);
    chk_int(g, 10, "old ratio completes after mid-period write");
    gap1(g); chk_int(g, 2, "new ratio after boundary");
    for (int i = 0; i < 31; i++) begin
      wr(i % 4, (i / 2) % 4, i % 5, (i % 3) == 0, 0, 0, 0, 0);
      run((i % 7) + 1);
    end
    run(100);

    tag = "R6";
    wr(1, 1, 2, 0, 1, 0, 0, 0);
    for (int i = 0; i < 20; i++) begin ctl0 = i[0] ^ i[2]; run(3); end
    ctl0 = 1'b1; run(10);

    tag = "R7";
    wr(2, 1, 2, 0, 0, 1, 0, 0);
    for (int i = 0; i < 20; i++) begin ctl0 = i[1]; run(2 + (i % 3)); end

    tag = "R8";
    wr(3, 1, 2, 0, 0, 0, 1, 0);
    ctl0 = 1'b1; run(5);
    ctl0 = 1'b0; run(5);
    ctl0 = 1'b1; run(30);
    ctl0 = 1'b0; run(1);
    ctl0 = 1'b1; run(20);

    tag = "R9";
    wr(0, 1, 3, 0, 0, 0, 0, 0);
    ctl1 = 1'b0; run(7);
    ctl1 = 1'b1; run(30);
    ctl1 = 1'b0; run(3);
    ctl1 = 1'b1; run(20);

    tag = "R10";
    wr(0, 1, 3, 0, 0, 0, 0, 1);
    run(5);
    ctl1 = 1'b0; run(6);
    ctl1 = 1'b1; run(40);
    ctl1 = 1'b0; run(1);
    ctl1 = 1'b1; run(30);

    chk_on = 1'b0;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule